// File: doc/BRIEF.md
# Seek Status Sequencer

This block is the device-side controller for a non-data seek on a parallel disk register interface. A host writes a target address and strobes a command. The block then drives the busy and seek-complete status bits, an interrupt request and an error register. The target can be given as cylinder, head and sector, or as a 28-bit logical block address. A countdown engine stands in for the head mechanics. The countdown is loaded from the cylinder distance between the current position and the target.

The block acknowledges a seek early. Busy stays low and the interrupt rises at once, while seek-complete stays low until the countdown ends. The host may write another command during that window. The block then raises busy, holds the command until the seek engine finishes, and executes it on the following cycle. The address fields that were written stay readable on the address outputs after the command.

Top module: `seek_status_seq`

## Requirements
- R1: After reset, bsy=0, dsc=1, intrq=0, err=0, err_reg=0, and the current cylinder is 0.
- R2: A command accepted while no seek runs executes at the strobe edge. Busy stays 0 and intrq becomes 1. For a valid seek (cmd_op=0), dsc becomes 0 at that edge. cmd_op=1 is a non-seek command that completes without error and without moving.
- R3: dsc stays 0 for exactly max(1, |target-current| * CYC_PER_CYL) cycles, then returns to 1. The target becomes the current cylinder.
- R4: A strobe while bsy=0 and dsc=0 raises bsy at that edge and clears intrq. Busy stays 1 until one cycle after dsc returns to 1. The held command then executes, busy falls and intrq rises.
- R5: A strobe while bsy=1 is ignored. It changes neither the address outputs nor the outcome of the held command.
- R6: In CHS mode (lba_mode=0) the target cylinder is cyl_in. In LBA mode the address is {head_in[3:0], cyl_in, sect_in}, and the target cylinder is that address divided by NUM_HEADS*NUM_SECT.
- R7: A seek to an unreachable target reports ID Not Found. Unreachable means a cylinder above MAX_CYL, or in CHS mode head ≥ NUM_HEADS, sector 0 or sector > NUM_SECT. The result is err_reg bit 4 set, err=1 and intrq=1, with dsc kept at 1 and the position unchanged.
- R8: cmd_op values 2 and 3 are invalid. They report Abort: err_reg bit 2 set, err=1, intrq=1, and no seek is started.
- R9: With power_low=1 at execution, a valid seek is skipped. dsc stays 1, the position is unchanged, and the command completes with no error.
- R10: cyl_out, head_out and sect_out show the fields of the last accepted command.
- R11: A command that completes without error clears err_reg and err. err is 1 exactly when err_reg bit 4 or bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 seek, 1 other non-data, 2/3 invalid |
| lba_mode | input | 1 | Address form: 1 LBA, 0 CHS |
| cyl_in | input | 16 | Cylinder field |
| head_in | input | 4 | Head field |
| sect_in | input | 8 | Sector field |
| power_low | input | 1 | Idle/standby power state |
| bsy | output | 1 | Busy status |
| dsc | output | 1 | Seek complete status |
| err | output | 1 | Error status |
| intrq | output | 1 | Interrupt request |
| err_reg | output | 8 | Error register (bit 4 ID Not Found, bit 2 Abort) |
| cyl_out | output | 16 | Echoed cylinder field |
| head_out | output | 4 | Echoed head field |
| sect_out | output | 8 | Echoed sector field |

## Verification
The assertions check the following on every cycle:
- the early acknowledge after each seek start;
- that a strobe during a seek raises busy;
- that busy cannot fall while seek-complete is low;
- that ID Not Found leaves seek-complete high;
- that the error summary bit agrees with the error register;
- that the echoed address stays fixed while busy.

The exact seek durations come only from the bench's scenarios. So do the LBA-to-cylinder mapping, the fact that failed or skipped seeks leave the position unchanged, and the fact that a strobe during busy is ignored. The bench covers these with sweeps over every pair of cylinders in a small configuration.

// File: rtl/seek_seq_pkg.sv
package seek_seq_pkg;

  typedef enum logic [1:0] {
    OP_SEEK = 2'b00,
    OP_MISC = 2'b01,
    OP_BAD2 = 2'b10,
    OP_BAD3 = 2'b11
  } op_e;

  localparam int ERR_IDNF_BIT = 4;
  localparam int ERR_ABRT_BIT = 2;

  function automatic logic [31:0] cyl_distance(logic [15:0] a, logic [15:0] b);
    return (a > b) ? 32'(a - b) : 32'(b - a);
  endfunction

  function automatic logic [31:0] seek_length(logic [15:0] cur, logic [15:0] tgt,
                                              logic [31:0] per_cyl);
    logic [31:0] n;
    n = cyl_distance(cur, tgt) * per_cyl;
    return (n == 32'd0) ? 32'd1 : n;
  endfunction

  function automatic logic [31:0] lba_cylinder(logic [27:0] lba, logic [31:0] per_cyl_blocks);
    return 32'(lba) / per_cyl_blocks;
  endfunction

endpackage

// File: rtl/seek_target_decode.sv
module seek_target_decode
  import seek_seq_pkg::*;
#(
  parameter int MAX_CYL   = 1023,
  parameter int NUM_HEADS = 16,
  parameter int NUM_SECT  = 63
) (
  input  logic        lba_mode,
  input  logic [15:0] cyl,
  input  logic [3:0]  head,
  input  logic [7:0]  sect,
  output logic [15:0] tgt_cyl,
  output logic        unreachable
);
  localparam logic [31:0] BLOCKS_PER_CYL = 32'(NUM_HEADS * NUM_SECT);

  logic [27:0] lba;
  logic [31:0] lba_cyl;
  logic        chs_bad;

  assign lba     = {head, cyl, sect};
  assign lba_cyl = lba_cylinder(lba, BLOCKS_PER_CYL);
  assign chs_bad = (32'(cyl) > 32'(MAX_CYL)) || (32'(head) >= 32'(NUM_HEADS)) ||
                   (sect == 8'd0) || (32'(sect) > 32'(NUM_SECT));

  always_comb begin
    if (lba_mode) begin
      tgt_cyl     = 16'(lba_cyl);
      unreachable = lba_cyl > 32'(MAX_CYL);
    end else begin
      tgt_cyl     = cyl;
      unreachable = chs_bad;
    end
  end
endmodule

// File: rtl/seek_engine.sv
module seek_engine
  import seek_seq_pkg::*;
#(
  parameter int CYC_PER_CYL = 4,
  parameter int CNT_W       = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] tgt_cyl,
  output logic        busy,
  output logic [15:0] cur_cyl
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain  <= '0;
      cur_cyl <= '0;
    end else if (start) begin
      remain  <= CNT_W'(seek_length(cur_cyl, tgt_cyl, 32'(CYC_PER_CYL)));
      cur_cyl <= tgt_cyl;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/seek_cmd_ctrl.sv
module seek_cmd_ctrl
  import seek_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic        lba_mode,
  input  logic [15:0] cyl_in,
  input  logic [3:0]  head_in,
  input  logic [7:0]  sect_in,
  input  logic        power_low,
  input  logic        engine_busy,
  input  logic        unreachable,
  output logic        dec_lba,
  output logic [15:0] dec_cyl,
  output logic [3:0]  dec_head,
  output logic [7:0]  dec_sect,
  output logic        bsy,
  output logic        intrq,
  output logic        err,
  output logic [7:0]  err_reg,
  output logic [15:0] cyl_q,
  output logic [3:0]  head_q,
  output logic [7:0]  sect_q,
  output logic        seek_start,
  output logic        idnf_evt,
  output logic        abort_evt
);
  logic accept, exec_now, lba_q, is_seek, is_bad;
  op_e  op_q, exec_op;
  logic [7:0] err_next;

  assign accept   = cmd_valid && !bsy;
  assign exec_now = (accept || bsy) && !engine_busy;
  assign exec_op  = bsy ? op_q : op_e'(cmd_op);

  assign dec_lba  = bsy ? lba_q  : lba_mode;
  assign dec_cyl  = bsy ? cyl_q  : cyl_in;
  assign dec_head = bsy ? head_q : head_in;
  assign dec_sect = bsy ? sect_q : sect_in;

  assign is_seek = (exec_op == OP_SEEK);
  assign is_bad  = (exec_op == OP_BAD2) || (exec_op == OP_BAD3);

  assign seek_start = exec_now && is_seek && !unreachable && !power_low;
  assign idnf_evt   = exec_now && is_seek && unreachable;
  assign abort_evt  = exec_now && is_bad;

  always_comb begin
    err_next               = '0;
    err_next[ERR_IDNF_BIT] = idnf_evt;
    err_next[ERR_ABRT_BIT] = abort_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsy     <= 1'b0;
      intrq   <= 1'b0;
      err     <= 1'b0;
      err_reg <= '0;
      cyl_q   <= '0;
      head_q  <= '0;
      sect_q  <= '0;
      lba_q   <= 1'b0;
      op_q    <= OP_SEEK;
    end else begin
      if (accept) begin
        cyl_q  <= cyl_in;
        head_q <= head_in;
        sect_q <= sect_in;
        lba_q  <= lba_mode;
        op_q   <= op_e'(cmd_op);
      end
      if (exec_now) begin
        bsy     <= 1'b0;
        intrq   <= 1'b1;
        err_reg <= err_next;
        err     <= idnf_evt || abort_evt;
      end else if (accept) begin
        bsy   <= 1'b1;
        intrq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seek_status_seq.sv
module seek_status_seq
  import seek_seq_pkg::*;
#(
  parameter int MAX_CYL     = 1023,
  parameter int CYC_PER_CYL = 4,
  parameter int NUM_HEADS   = 16,
  parameter int NUM_SECT    = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic        lba_mode,
  input  logic [15:0] cyl_in,
  input  logic [3:0]  head_in,
  input  logic [7:0]  sect_in,
  input  logic        power_low,
  output logic        bsy,
  output logic        dsc,
  output logic        err,
  output logic        intrq,
  output logic [7:0]  err_reg,
  output logic [15:0] cyl_out,
  output logic [3:0]  head_out,
  output logic [7:0]  sect_out
);
  localparam int CNT_W = $clog2(MAX_CYL * CYC_PER_CYL + 2);

  logic        dec_lba, unreachable, engine_busy;
  logic [15:0] dec_cyl, tgt_cyl, cur_cyl;
  logic [3:0]  dec_head;
  logic [7:0]  dec_sect;
  logic        seek_start, idnf_evt, abort_evt;

  seek_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .lba_mode(lba_mode), .cyl_in(cyl_in), .head_in(head_in), .sect_in(sect_in),
    .power_low(power_low), .engine_busy(engine_busy), .unreachable(unreachable),
    .dec_lba(dec_lba), .dec_cyl(dec_cyl), .dec_head(dec_head), .dec_sect(dec_sect),
    .bsy(bsy), .intrq(intrq), .err(err), .err_reg(err_reg),
    .cyl_q(cyl_out), .head_q(head_out), .sect_q(sect_out),
    .seek_start(seek_start), .idnf_evt(idnf_evt), .abort_evt(abort_evt)
  );

  seek_target_decode #(
    .MAX_CYL(MAX_CYL), .NUM_HEADS(NUM_HEADS), .NUM_SECT(NUM_SECT)
  ) u_decode (
    .lba_mode(dec_lba), .cyl(dec_cyl), .head(dec_head), .sect(dec_sect),
    .tgt_cyl(tgt_cyl), .unreachable(unreachable)
  );

  seek_engine #(
    .CYC_PER_CYL(CYC_PER_CYL), .CNT_W(CNT_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(seek_start), .tgt_cyl(tgt_cyl),
    .busy(engine_busy), .cur_cyl(cur_cyl)
  );

  assign dsc = !engine_busy;
endmodule

// File: rtl/seek_status_chk.sv
module seek_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        bsy,
  input logic        dsc,
  input logic        err,
  input logic        intrq,
  input logic [7:0]  err_reg,
  input logic [15:0] cyl_out,
  input logic [3:0]  head_out,
  input logic [7:0]  sect_out,
  input logic        seek_start,
  input logic        idnf_evt,
  input logic        abort_evt
);
  assert_early_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seek_start |=> (!dsc && intrq && !bsy));

  assert_hold_raises_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !bsy && !dsc) |=> (bsy && !intrq));

  assert_busy_until_seek_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && !dsc) |=> bsy);

  assert_idnf_keeps_dsc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idnf_evt |=> (dsc && err && err_reg[4] && intrq));

  assert_abort_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (err && err_reg[2] && dsc));

  assert_err_summary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err == (err_reg[4] || err_reg[2]));

  assert_echo_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bsy |=> ($stable(cyl_out) && $stable(head_out) && $stable(sect_out)));
endmodule

bind seek_status_seq seek_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .bsy(bsy), .dsc(dsc),
  .err(err), .intrq(intrq), .err_reg(err_reg), .cyl_out(cyl_out),
  .head_out(head_out), .sect_out(sect_out), .seek_start(seek_start),
  .idnf_evt(idnf_evt), .abort_evt(abort_evt)
);

// File: tb/test_seek_status_seq.sv
module test_seek_status_seq;
  localparam int MAXC = 20;
  localparam int CPC  = 3;
  localparam int NH   = 4;
  localparam int NS   = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cmd_valid, lba_mode, power_low;
  logic [1:0]  cmd_op;
  logic [15:0] cyl_in;
  logic [3:0]  head_in;
  logic [7:0]  sect_in;
  logic        bsy, dsc, err, intrq;
  logic [7:0]  err_reg;
  logic [15:0] cyl_out;
  logic [3:0]  head_out;
  logic [7:0]  sect_out;

  int checks = 0, fails = 0, ecur = 0, cyc = 0;
  bit done = 1'b0;

  seek_status_seq #(.MAX_CYL(MAXC), .CYC_PER_CYL(CPC), .NUM_HEADS(NH), .NUM_SECT(NS))
  i_seek_status_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .lba_mode(lba_mode), .cyl_in(cyl_in), .head_in(head_in), .sect_in(sect_in),
    .power_low(power_low), .bsy(bsy), .dsc(dsc), .err(err), .intrq(intrq),
    .err_reg(err_reg), .cyl_out(cyl_out), .head_out(head_out), .sect_out(sect_out)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(int t);
    int d;
    d = ((t > ecur) ? t - ecur : ecur - t) * CPC;
    return (d == 0) ? 1 : d;
  endfunction

  // called at a negedge; returns at the negedge after the strobe edge
  task automatic strobe(logic [1:0] op, logic lba, logic [15:0] c, logic [3:0] h, logic [7:0] s);
    cmd_valid = 1'b1; cmd_op = op; lba_mode = lba;
    cyl_in = c; head_in = h; sect_in = s;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic count_dsc_low(output int n);
    n = 0;
    while (dsc == 1'b0 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic seek_to(logic lba, logic [15:0] c, logic [3:0] h, logic [7:0] s, int tgt);
    int n;
    strobe(2'd0, lba, c, h, s);
    chk("R2 bsy low after seek strobe", int'(bsy), 0);
    chk("R2 intrq early", int'(intrq), 1);
    chk("R2 dsc drops", int'(dsc), 0);
    chk("R11 err_reg cleared", int'(err_reg), 0);
    chk("R10 cyl echo", int'(cyl_out), int'(c));
    chk("R10 head echo", int'(head_out), int'(h));
    chk("R10 sect echo", int'(sect_out), int'(s));
    count_dsc_low(n);
    chk(lba ? "R6 LBA seek length" : "R3 seek length", n, exp_len(tgt));
    ecur = tgt;
  endtask

  task automatic seek_chs(int t);
    seek_to(1'b0, 16'(t), 4'(t % NH), 8'(1 + t % NS), t);
  endtask

  task automatic expect_idnf(logic lba, logic [15:0] c, logic [3:0] h, logic [7:0] s);
    strobe(2'd0, lba, c, h, s);
    chk("R7 idnf bit", int'(err_reg), 16);
    chk("R7 err status", int'(err), 1);
    chk("R7 dsc stays high", int'(dsc), 1);
    chk("R7 intrq", int'(intrq), 1);
    @(negedge clk);
    chk("R7 dsc still high", int'(dsc), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; lba_mode = 1'b0;
    cyl_in = '0; head_in = '0; sect_in = 8'd1; power_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bsy", int'(bsy), 0);
    chk("R1 dsc", int'(dsc), 1);
    chk("R1 intrq", int'(intrq), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 err_reg", int'(err_reg), 0);

    // R1 position 0 and R3: all ordered pairs of cylinders
    for (int a = 0; a <= MAXC; a++) begin
      for (int b = 0; b <= MAXC; b++) begin
        seek_chs(a);
        seek_chs(b);
      end
    end

    // R6 LBA mapping over all cylinders, with varied block offsets
    for (int c = 0; c <= MAXC; c++) begin
      int lba;
      lba = c * NH * NS + (c * 5) % (NH * NS);
      seek_to(1'b1, 16'(lba >> 8), 4'(lba >> 24), 8'(lba), c);
    end

    // R7 unreachable targets, position kept
    seek_chs(7);
    expect_idnf(1'b0, 16'(MAXC + 1), 4'd0, 8'd1);
    expect_idnf(1'b0, 16'd3, 4'(NH), 8'd1);
    expect_idnf(1'b0, 16'd3, 4'd0, 8'd0);
    expect_idnf(1'b0, 16'd3, 4'd0, 8'(NS + 1));
    expect_idnf(1'b1, 16'(((MAXC + 1) * NH * NS) >> 8), 4'd0, 8'(((MAXC + 1) * NH * NS)));
    seek_chs(12);

    // R8 invalid codes
    for (int op = 2; op < 4; op++) begin
      strobe(2'(op), 1'b0, 16'd1, 4'd0, 8'd1);
      chk("R8 abort bit", int'(err_reg), 4);
      chk("R8 err status", int'(err), 1);
      chk("R8 no seek", int'(dsc), 1);
    end

    // R2 non-seek command completes immediately, R11 clears error
    strobe(2'd1, 1'b0, 16'd9, 4'd1, 8'd2);
    chk("R2 misc bsy", int'(bsy), 0);
    chk("R2 misc intrq", int'(intrq), 1);
    chk("R11 misc err_reg", int'(err_reg), 0);
    chk("R2 misc no seek", int'(dsc), 1);
    seek_chs(4);

    // R9 low power skips the seek
    power_low = 1'b1;
    strobe(2'd0, 1'b0, 16'd18, 4'd0, 8'd1);
    chk("R9 dsc stays high", int'(dsc), 1);
    chk("R9 no error", int'(err_reg), 0);
    chk("R9 intrq", int'(intrq), 1);
    @(negedge clk);
    chk("R9 dsc still high", int'(dsc), 1);
    power_low = 1'b0;
    seek_chs(10);

    // R4/R5 held non-seek command during long seek
    seek_chs(0);
    strobe(2'd0, 1'b0, 16'd20, 4'd0, 8'd1);
    chk("R2 long seek dsc", int'(dsc), 0);
    repeat (3) @(negedge clk);
    strobe(2'd1, 1'b0, 16'd5, 4'd2, 8'd3);
    chk("R4 bsy raised", int'(bsy), 1);
    chk("R4 intrq cleared", int'(intrq), 0);
    strobe(2'd2, 1'b0, 16'd7, 4'd1, 8'd4);
    chk("R5 echo kept", int'(cyl_out), 5);
    count_dsc_low(n);
    chk("R4 still busy at dsc rise", int'(bsy), 1);
    @(negedge clk);
    chk("R4 bsy released", int'(bsy), 0);
    chk("R4 intrq after release", int'(intrq), 1);
    chk("R5 ignored abort", int'(err_reg), 0);
    chk("R5 echo after release", int'(cyl_out), 5);
    ecur = 20;

    // R4 held seek runs after the current one
    strobe(2'd0, 1'b0, 16'd2, 4'd0, 8'd1);
    @(negedge clk);
    strobe(2'd0, 1'b0, 16'd10, 4'd0, 8'd1);
    chk("R4 held seek bsy", int'(bsy), 1);
    count_dsc_low(n);
    @(negedge clk);
    chk("R4 held seek started", int'(dsc), 0);
    chk("R4 held seek bsy low", int'(bsy), 0);
    ecur = 2;
    count_dsc_low(n);
    chk("R4 held seek length", n, exp_len(10));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule